// File: doc/BRIEF.md
# Microcoded Routine Sequencer

This block holds a small instruction store and plays short downloaded routines out to an external associative-memory device. A host fills the store entry by entry. Each entry is written or read in two 16-bit host cycles through an address pointer that advances on its own. Six start-address registers mark where each routine begins. A start request names one of six routines. The sequencer then executes one entry per clock. For each entry aimed at the device it drives the entry's data word and three strobe levels, and it stops after an entry that carries the end bit.

Routines 0 and 1 are fast routines. Their first entry is fetched in the same cycle the start is accepted, so the device sees it one clock earlier than for routines 2 to 5, and the fetch pointer continues from the start address plus one. Internal entries never reach the device. One internal op-code waits for a match: if the match input is low it jumps to the address held in the entry, and if the match input is high it falls through to the next entry. Requests that arrive while a routine is running are held. They are served one at a time, lowest routine number first.

Top module: `routine_seq`

## Requirements
- R1: A host write cycle with the phase at 0 stores `host_wdata` as the data word of the entry at the pointer. The next write cycle stores the low byte as the control byte: bits [2:0] are the strobe levels (bit 0 write, bit 1 command, bit 2 enable), bit 3 is the internal flag, bit 4 is the end bit and bits [7:5] are the length. The pointer advances after the second cycle. Reads follow the same two phases: `host_rdata` shows the data word at phase 0 and `{8'h00, control byte}` at phase 1.
- R2: A pointer load sets the pointer, and the next host cycle is treated as phase 0. The pointer wraps from 63 to 0.
- R3: A start request for routine 2, 3, 4 or 5 that is accepted at a clock edge costs one load cycle, in which `busy` is high and `dev_valid` is low. The entry at the routine's start address is issued after the following edge.
- R4: A start request for routine 0 or 1 that is accepted at an edge issues the entry at the start address right after that edge. Execution then continues from the start address plus one.
- R5: While running, the sequencer issues one entry per clock in address order. After an entry with the end bit, `busy` is low on the next cycle.
- R6: An internal entry whose word has bits [15:12] = 4'h1 is a wait-for-match. If `match_in` is low, the next entry executed is the one at the address in word bits [5:0].
- R7: At a wait-for-match entry with `match_in` high, execution falls through to the next sequential entry.
- R8: Requests that arrive while a routine runs are held pending. Each starts only after the current routine ends, and the lowest-numbered pending routine starts first.
- R9: An internal entry does not drive the device: `dev_valid` is low, `dev_data` is zero and `dev_strobe` is 3'b111. The same holds whenever no entry is being issued.
- R10: After reset the sequencer is idle, `dev_valid` is low, the strobes are all high, no request is pending and the host pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ptr_ld | input | 1 | Load the host address pointer and reset the phase |
| host_ptr_val | input | 6 | Value for a pointer load |
| host_wr | input | 1 | Host write cycle |
| host_rd | input | 1 | Host read cycle (advances the phase) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the current phase |
| sa_we | input | 1 | Write a start-address register |
| sa_sel | input | 3 | Which routine's start address is written |
| sa_val | input | 6 | Start address value |
| start_req | input | 6 | One bit per routine that requests a start |
| match_in | input | 1 | Match result from the external device |
| dev_valid | output | 1 | A device entry is being issued this cycle |
| dev_data | output | 16 | Op-code or data word for the device |
| dev_strobe | output | 3 | Strobe levels {enable, command, write} |
| dev_len | output | 3 | Length field of the issued entry |
| busy | output | 1 | A routine is loading or running |

## Verification
The assertions check on every cycle that the idle strobe levels hold whenever nothing is issued, that the host pointer advances only after the second phase, that a wait-for-match goes either to its target or to the next address depending on `match_in`, and that an end entry always leaves the sequencer idle. Only the bench's scenarios can show the full order of issued words, which covers the one-cycle start advantage of routines 0 and 1, the held requests and their priority order, and the round trip of store contents through the host read phases, including the wrap at the top of the pointer.

// File: rtl/routine_seq_pkg.sv
package routine_seq_pkg;

  localparam int WORD_W = 16;
  localparam int CTL_W  = 8;
  localparam logic [3:0] OP_WAIT_MATCH = 4'h1;

  typedef struct packed {
    logic [2:0] len;
    logic       last;
    logic       internal;
    logic [2:0] strobe;
  } ctl_t;

  function automatic logic is_wait_op(input logic [WORD_W-1:0] w);
    return w[15:12] == OP_WAIT_MATCH;
  endfunction

  function automatic logic fast_routine(input int unsigned id, input int unsigned fast_cnt);
    return id < fast_cnt;
  endfunction

endpackage

// File: rtl/seq_store.sv
module seq_store #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                                clk,
  input  logic                                wr_word,
  input  logic                                wr_ctl,
  input  logic [AW-1:0]                       wr_addr,
  input  logic [routine_seq_pkg::WORD_W-1:0]  wdata,
  output logic [routine_seq_pkg::WORD_W-1:0]  h_word,
  output routine_seq_pkg::ctl_t               h_ctl,
  input  logic [AW-1:0]                       f_addr,
  output logic [routine_seq_pkg::WORD_W-1:0]  f_word,
  output routine_seq_pkg::ctl_t               f_ctl
);
  import routine_seq_pkg::*;

  logic [WORD_W-1:0] word_mem [DEPTH];
  ctl_t              ctl_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_word) word_mem[wr_addr] <= wdata;
    if (wr_ctl)  ctl_mem[wr_addr]  <= ctl_t'(wdata[CTL_W-1:0]);
  end

  assign h_word = word_mem[wr_addr];
  assign h_ctl  = ctl_mem[wr_addr];
  assign f_word = word_mem[f_addr];
  assign f_ctl  = ctl_mem[f_addr];
endmodule

// File: rtl/seq_host.sv
module seq_host #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_ld,
  input  logic [AW-1:0] ptr_val,
  input  logic          wr,
  input  logic          rd,
  output logic [AW-1:0] hptr,
  output logic          phase,
  output logic          wr_word,
  output logic          wr_ctl
);
  logic cycle;
  assign cycle   = (wr | rd) & ~ptr_ld;
  assign wr_word = wr & ~ptr_ld & ~phase;
  assign wr_ctl  = wr & ~ptr_ld & phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hptr  <= '0;
      phase <= 1'b0;
    end else if (ptr_ld) begin
      hptr  <= ptr_val;
      phase <= 1'b0;
    end else if (cycle) begin
      phase <= ~phase;
      if (phase) hptr <= hptr + AW'(1);
    end
  end
endmodule

// File: rtl/seq_arb.sv
module seq_arb #(
  parameter int NR = 6,
  parameter int RW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] req,
  input  logic          grant_en,
  output logic          grant_vld,
  output logic [RW-1:0] grant_id,
  output logic [NR-1:0] pend
);
  logic [NR-1:0] cand, grant_oh;

  assign cand = pend | req;

  always_comb begin
    grant_vld = 1'b0;
    grant_id  = '0;
    grant_oh  = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (cand[i]) begin
        grant_id  = RW'(i);
        grant_oh  = NR'(1) << i;
      end
    end
    if (grant_en && cand != '0) grant_vld = 1'b1;
    else                        grant_oh  = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= cand & ~grant_oh;
  end
endmodule

// File: rtl/seq_core.sv
module seq_core #(
  parameter int AW       = 6,
  parameter int NR       = 6,
  parameter int RW       = $clog2(NR),
  parameter int FAST_CNT = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                grant_vld,
  input  logic [RW-1:0]                       grant_id,
  input  logic [NR-1:0][AW-1:0]               sa_tbl,
  input  logic                                match_in,
  output logic [AW-1:0]                       f_addr,
  input  logic [routine_seq_pkg::WORD_W-1:0]  f_word,
  input  routine_seq_pkg::ctl_t               f_ctl,
  output logic [routine_seq_pkg::WORD_W-1:0]  cur_word,
  output routine_seq_pkg::ctl_t               cur_ctl,
  output logic                                cur_valid,
  output logic [AW-1:0]                       cur_addr,
  output logic                                loading,
  output logic                                idle,
  output logic                                wait_hit,
  output logic                                end_hit,
  output logic [AW-1:0]                       wait_tgt
);
  import routine_seq_pkg::*;

  logic [AW-1:0] ip;
  logic          fast_go;

  assign idle     = ~cur_valid & ~loading;
  assign fast_go  = idle & grant_vld & fast_routine(int'(grant_id), FAST_CNT);
  assign wait_hit = cur_valid & cur_ctl.internal & is_wait_op(cur_word);
  assign end_hit  = cur_valid & cur_ctl.last;
  assign wait_tgt = cur_word[AW-1:0];

  always_comb begin
    if (fast_go)                   f_addr = sa_tbl[grant_id];
    else if (wait_hit && !match_in) f_addr = wait_tgt;
    else                           f_addr = ip;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip        <= '0;
      cur_word  <= '0;
      cur_ctl   <= '0;
      cur_valid <= 1'b0;
      cur_addr  <= '0;
      loading   <= 1'b0;
    end else if (idle) begin
      if (fast_go) begin
        cur_word  <= f_word;
        cur_ctl   <= f_ctl;
        cur_valid <= 1'b1;
        cur_addr  <= f_addr;
        ip        <= f_addr + AW'(1);
      end else if (grant_vld) begin
        loading <= 1'b1;
        ip      <= sa_tbl[grant_id];
      end
    end else if (loading || !end_hit) begin
      loading   <= 1'b0;
      cur_word  <= f_word;
      cur_ctl   <= f_ctl;
      cur_valid <= 1'b1;
      cur_addr  <= f_addr;
      ip        <= f_addr + AW'(1);
    end else begin
      cur_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/routine_seq.sv
module routine_seq #(
  parameter int DEPTH    = 64,
  parameter int NR       = 6,
  parameter int FAST_CNT = 2,
  parameter int AW       = $clog2(DEPTH),
  parameter int SW       = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_ptr_ld,
  input  logic [AW-1:0] host_ptr_val,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  input  logic          sa_we,
  input  logic [SW-1:0] sa_sel,
  input  logic [AW-1:0] sa_val,
  input  logic [NR-1:0] start_req,
  input  logic          match_in,
  output logic          dev_valid,
  output logic [15:0]   dev_data,
  output logic [2:0]    dev_strobe,
  output logic [2:0]    dev_len,
  output logic          busy
);
  import routine_seq_pkg::*;

  logic [AW-1:0]         hptr, f_addr, cur_addr, wait_tgt;
  logic                  hphase, wr_word, wr_ctl;
  logic [WORD_W-1:0]     h_word, f_word, cur_word;
  ctl_t                  h_ctl, f_ctl, cur_ctl;
  logic                  grant_vld, cur_valid, loading, idle, wait_hit, end_hit;
  logic [SW-1:0]         grant_id;
  logic [NR-1:0]         pend;
  logic [NR-1:0][AW-1:0] sa_tbl;

  always_ff @(posedge clk) begin
    if (!rst_n) sa_tbl <= '0;
    else if (sa_we && int'(sa_sel) < NR) sa_tbl[sa_sel] <= sa_val;
  end

  seq_host #(.AW(AW)) host_i (
    .clk(clk), .rst_n(rst_n), .ptr_ld(host_ptr_ld), .ptr_val(host_ptr_val),
    .wr(host_wr), .rd(host_rd), .hptr(hptr), .phase(hphase),
    .wr_word(wr_word), .wr_ctl(wr_ctl)
  );

  seq_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .clk(clk), .wr_word(wr_word), .wr_ctl(wr_ctl), .wr_addr(hptr),
    .wdata(host_wdata), .h_word(h_word), .h_ctl(h_ctl),
    .f_addr(f_addr), .f_word(f_word), .f_ctl(f_ctl)
  );

  seq_arb #(.NR(NR), .RW(SW)) arb_i (
    .clk(clk), .rst_n(rst_n), .req(start_req), .grant_en(idle),
    .grant_vld(grant_vld), .grant_id(grant_id), .pend(pend)
  );

  seq_core #(.AW(AW), .NR(NR), .RW(SW), .FAST_CNT(FAST_CNT)) core_i (
    .clk(clk), .rst_n(rst_n), .grant_vld(grant_vld), .grant_id(grant_id),
    .sa_tbl(sa_tbl), .match_in(match_in), .f_addr(f_addr), .f_word(f_word),
    .f_ctl(f_ctl), .cur_word(cur_word), .cur_ctl(cur_ctl), .cur_valid(cur_valid),
    .cur_addr(cur_addr), .loading(loading), .idle(idle), .wait_hit(wait_hit),
    .end_hit(end_hit), .wait_tgt(wait_tgt)
  );

  assign host_rdata = hphase ? {8'h00, h_ctl} : h_word;
  assign dev_valid  = cur_valid & ~cur_ctl.internal;
  assign dev_data   = dev_valid ? cur_word : '0;
  assign dev_strobe = dev_valid ? cur_ctl.strobe : 3'b111;
  assign dev_len    = dev_valid ? cur_ctl.len : '0;
  assign busy       = ~idle;
endmodule

// File: rtl/routine_seq_chk.sv
module routine_seq_chk #(
  parameter int AW = 6,
  parameter int NR = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_ptr_ld,
  input logic          host_wr,
  input logic          host_rd,
  input logic [AW-1:0] hptr,
  input logic          hphase,
  input logic          dev_valid,
  input logic [2:0]    dev_strobe,
  input logic [15:0]   dev_data,
  input logic          busy,
  input logic          match_in,
  input logic          wait_hit,
  input logic          end_hit,
  input logic [AW-1:0] cur_addr,
  input logic [AW-1:0] wait_tgt,
  input logic [NR-1:0] pend
);
  // R9: nothing issued means idle strobe levels and a zero word
  p_idle_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_valid |-> (dev_strobe == 3'b111 && dev_data == 16'h0));

  // R5: device activity implies the sequencer is busy
  p_valid_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |-> busy);

  // R5: an end entry leaves the sequencer idle next cycle
  p_end_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    end_hit |=> !busy);

  // R1: pointer advances after the second phase only
  p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_wr || host_rd) && !host_ptr_ld && hphase) |=> hptr == AW'($past(hptr) + 1));

  p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_wr || host_rd) && !host_ptr_ld && !hphase) |=> (hptr == $past(hptr) && hphase));

  // R6: wait without match goes to the target
  p_wait_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_hit && !end_hit && !match_in) |=> cur_addr == $past(wait_tgt));

  // R7: wait with match falls through
  p_wait_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_hit && !end_hit && match_in) |=> cur_addr == AW'($past(cur_addr) + 1));

  // R8: a pending request never coexists with an idle sequencer for two cycles
  p_pend_served_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0 && !busy) |=> busy);
endmodule

bind routine_seq routine_seq_chk #(.AW(AW), .NR(NR)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_ptr_ld(host_ptr_ld), .host_wr(host_wr),
  .host_rd(host_rd), .hptr(hptr), .hphase(hphase), .dev_valid(dev_valid),
  .dev_strobe(dev_strobe), .dev_data(dev_data), .busy(busy), .match_in(match_in),
  .wait_hit(wait_hit), .end_hit(end_hit), .cur_addr(cur_addr),
  .wait_tgt(wait_tgt), .pend(pend)
);

// File: tb/routine_seq_tb.sv
module routine_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_ptr_ld = 0, host_wr = 0, host_rd = 0;
  logic [5:0]  host_ptr_val = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic        sa_we = 0;
  logic [2:0]  sa_sel = '0;
  logic [5:0]  sa_val = '0;
  logic [5:0]  start_req = '0;
  logic        match_in = 0;
  logic        dev_valid, busy;
  logic [15:0] dev_data;
  logic [2:0]  dev_strobe, dev_len;

  int checks = 0, fails = 0;
  logic [18:0] exp_q [$];

  always #5 clk = ~clk;

  routine_seq dut_i (
    .clk(clk), .rst_n(rst_n), .host_ptr_ld(host_ptr_ld), .host_ptr_val(host_ptr_val),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sa_we(sa_we), .sa_sel(sa_sel), .sa_val(sa_val), .start_req(start_req),
    .match_in(match_in), .dev_valid(dev_valid), .dev_data(dev_data),
    .dev_strobe(dev_strobe), .dev_len(dev_len), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ctl byte: {len[2:0], end, internal, strobe[2:0]}
  function automatic logic [7:0] ctl(input logic [2:0] len, input logic last,
                                     input logic internal, input logic [2:0] stb);
    return {len, last, internal, stb};
  endfunction

  task automatic expect_issue(input logic [15:0] d, input logic [2:0] s);
    exp_q.push_back({s, d});
  endtask

  // monitor: pops expected device words as they are issued (R5)
  always @(negedge clk) begin
    if (rst_n && dev_valid) begin
      if (exp_q.size() == 0) check("R5 unexpected issue", {13'h0, dev_strobe, dev_data}, 32'hFFFF_FFFF);
      else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        check("R5 issue order", {13'h0, dev_strobe, dev_data}, {13'h0, e});
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic load_ptr(input logic [5:0] p);
    tick(); host_ptr_ld = 1; host_ptr_val = p;
    tick(); host_ptr_ld = 0;
  endtask

  task automatic put(input logic [15:0] w, input logic [7:0] c);
    host_wr = 1; host_wdata = w; tick();
    host_wdata = {8'h00, c}; tick();
    host_wr = 0;
  endtask

  task automatic get(input logic [15:0] w, input logic [7:0] c);
    @(negedge clk); check("R1 read word phase", host_rdata, w);
    tick(); host_rd = 1;
    tick();
    @(negedge clk); check("R1 read ctl phase", host_rdata, {8'h00, c});
    tick(); host_rd = 0;
  endtask

  task automatic set_sa(input int r, input logic [5:0] a);
    tick(); sa_we = 1; sa_sel = 3'(r); sa_val = a;
    tick(); sa_we = 0;
  endtask

  task automatic pulse(input logic [5:0] r);
    tick(); start_req = r;
    tick(); start_req = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", busy, 0);
    check("R10 dev_valid", dev_valid, 0);
    check("R10 strobe", dev_strobe, 3'b111);

    // R10: first write lands at pointer 0 without any load
    put(16'h0BAD, ctl(3'd2, 1'b0, 1'b1, 3'b000));
    load_ptr(6'd0);
    get(16'h0BAD, ctl(3'd2, 1'b0, 1'b1, 3'b000));

    // Program: routine 2 @10, 0 @20, 3 @30 (wait->40), 1 @50
    load_ptr(6'd10);
    put(16'hA010, ctl(3'd1, 0, 0, 3'b010));
    put(16'hA011, ctl(3'd1, 0, 0, 3'b001));
    put(16'hA012, ctl(3'd1, 1, 0, 3'b100));
    load_ptr(6'd20);
    put(16'hA020, ctl(3'd1, 0, 0, 3'b011));
    put(16'hA021, ctl(3'd1, 1, 0, 3'b110));
    load_ptr(6'd30);
    put(16'h1028, ctl(3'd1, 0, 1, 3'b000));   // wait-for-match, target 40
    put(16'hA031, ctl(3'd1, 1, 0, 3'b101));
    load_ptr(6'd40);
    put(16'hA040, ctl(3'd1, 1, 0, 3'b000));
    load_ptr(6'd50);
    put(16'h0000, ctl(3'd1, 0, 1, 3'b000));   // internal no-op
    put(16'hA051, ctl(3'd1, 1, 0, 3'b011));

    // R1 readback with auto-increment across two entries
    load_ptr(6'd10);
    get(16'hA010, ctl(3'd1, 0, 0, 3'b010));
    get(16'hA011, ctl(3'd1, 0, 0, 3'b001));

    // R2 wrap 63 -> 0
    load_ptr(6'd63);
    put(16'h6363, ctl(3'd7, 0, 1, 3'b000));
    put(16'h0F0F, ctl(3'd5, 1, 1, 3'b000));
    load_ptr(6'd0);
    get(16'h0F0F, ctl(3'd5, 1, 1, 3'b000));
    load_ptr(6'd63);
    get(16'h6363, ctl(3'd7, 0, 1, 3'b000));

    set_sa(0, 6'd20); set_sa(1, 6'd50); set_sa(2, 6'd10); set_sa(3, 6'd30);

    // R3 routine 2: load cycle then first entry
    expect_issue(16'hA010, 3'b010); expect_issue(16'hA011, 3'b001); expect_issue(16'hA012, 3'b100);
    pulse(6'b000100);
    @(negedge clk);
    check("R3 load cycle busy", busy, 1);
    check("R3 load cycle no issue", dev_valid, 0);
    @(negedge clk);
    check("R3 first entry", dev_data, 16'hA010);
    wait_idle();
    check("R5 idle after end", busy, 0);

    // R4 routine 0: first entry right after acceptance
    expect_issue(16'hA020, 3'b011); expect_issue(16'hA021, 3'b110);
    pulse(6'b000001);
    @(negedge clk);
    check("R4 fast first entry", dev_data, 16'hA020);
    @(negedge clk);
    check("R4 continues at start+1", dev_data, 16'hA021);
    wait_idle();

    // R6 routine 3 with no match: jumps to 40
    match_in = 0;
    expect_issue(16'hA040, 3'b000);
    pulse(6'b001000);
    @(negedge clk);
    @(negedge clk);
    check("R9 wait entry not issued", dev_valid, 0);
    check("R9 wait entry strobes", dev_strobe, 3'b111);
    @(negedge clk);
    check("R6 jump target", dev_data, 16'hA040);
    wait_idle();

    // R7 routine 3 with match: falls through to 31
    match_in = 1;
    expect_issue(16'hA031, 3'b101);
    pulse(6'b001000);
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R7 fall through", dev_data, 16'hA031);
    wait_idle();

    // R9 routine 1: internal no-op then device entry
    expect_issue(16'hA051, 3'b011);
    pulse(6'b000010);
    @(negedge clk);
    check("R9 no-op busy", busy, 1);
    check("R9 no-op data zero", dev_data, 16'h0);
    @(negedge clk);
    check("R9 next entry", dev_data, 16'hA051);
    wait_idle();

    // R8 held requests, lowest first: run 2, then request 3 and 0 together
    expect_issue(16'hA010, 3'b010); expect_issue(16'hA011, 3'b001); expect_issue(16'hA012, 3'b100);
    expect_issue(16'hA020, 3'b011); expect_issue(16'hA021, 3'b110);
    expect_issue(16'hA031, 3'b101);
    pulse(6'b000100);
    start_req = 6'b001001;
    tick(); start_req = '0;
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    wait_idle();
    check("R8 all held routines served", exp_q.size(), 0);
    check("R8 idle at end", busy, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule